// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Decimal Adjust

This block holds the 8-bit accumulator of a small microcontroller core together with its carry and digit-carry (auxiliary carry) flags. On each clock where the load strobe is high, it applies the operation named by the opcode select to the current accumulator and to the operand byte. The operand byte is supplied by the surrounding core, which fetches it from a working register, from data memory or from an immediate field. The new accumulator and flags are registered. The accumulator-zero output is derived from the live accumulator register and not from a stored flag.

The block supports binary addition with and without carry-in, bitwise AND, OR and XOR, increment, decrement, clear, complement, nibble swap, and rotates. Rotates are either 8-bit circular or 9-bit through carry. A decimal-adjust step turns the binary sum of two packed BCD bytes into packed BCD, using the digit-carry flag captured by the add. A low-nibble exchange trades accumulator bits 3:0 with bits 3:0 of a RAM byte presented on the operand input. The byte to be written back to RAM appears on a dedicated output, together with a one-cycle write pulse. No subtract opcode exists: software subtracts by complementing, adding and complementing again.

The load strobe is a plain control pin with no back-pressure. The block accepts an operation on every strobed cycle, and the core must hold off the strobe itself.

Top module: `acc_alu_core`

## Requirements
- R1: While rst_n is low, and after its release until the first strobe, acc_q is 00h, carry_q and aux_q are 0, acc_zero is 1, and ram_we is 0.
- R2: Opcode 1 (add) sets acc_q to (acc + operand) mod 256. Opcode 2 (add with carry) also adds carry_q. In both, carry_q takes the carry out of bit 7 and aux_q takes the carry out of bit 3.
- R3: Opcodes 0 (load operand), 3 (AND), 4 (OR), 5 (XOR), 6 (increment mod 256), 7 (decrement mod 256), 8 (clear) and 9 (complement) produce their result in acc_q and leave carry_q and aux_q unchanged.
- R4: Opcode 10 swaps acc_q bits 7:4 with bits 3:0 and leaves both flags unchanged.
- R5: Opcode 11 rotates left circularly (bit 7 goes to bit 0) and opcode 13 rotates right circularly (bit 0 goes to bit 7). Both leave the flags unchanged.
- R6: Opcode 12 rotates left through carry: the old carry_q enters bit 0 and the old bit 7 becomes carry_q. Opcode 14 rotates right through carry: the old carry_q enters bit 7 and the old bit 0 becomes carry_q. aux_q is unchanged.
- R7: Opcode 15 (decimal adjust) first adds 06h if acc bits 3:0 exceed 9 or aux_q is set. It then adds 60h if bits 7:4 of that intermediate exceed 9, or carry_q is set, or the first step overflowed. carry_q is set if either step overflows and is kept otherwise. aux_q is unchanged.
- R8: Opcode 16 (nibble exchange) loads acc bits 3:0 from operand bits 3:0 and keeps acc bits 7:4. In the next cycle, ram_wdata is {operand bits 7:4, old acc bits 3:0} and ram_we is high for exactly that one cycle. Flags are unchanged.
- R9: With ld_en low, or with an opcode from 17 to 31, acc_q, carry_q and aux_q keep their values, and ram_we is low in the following cycle.
- R10: acc_zero is high exactly when acc_q is 00h, in the same cycle.
- R11: Complement, then add a value, then complement again leaves (original - value) mod 256 in acc_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe: apply op_sel this cycle |
| op_sel | input | 5 | Operation code (see requirements) |
| operand | input | 8 | Operand byte or RAM byte for the nibble exchange |
| acc_q | output | 8 | Accumulator register |
| carry_q | output | 1 | Carry flag |
| aux_q | output | 1 | Digit (auxiliary) carry flag |
| acc_zero | output | 1 | High when the accumulator is zero |
| ram_wdata | output | 8 | Write-back byte for the nibble exchange |
| ram_we | output | 1 | One-cycle write strobe for ram_wdata |

## Verification
All state is visible at the ports. A wrong accumulator bit shows in acc_q and acc_zero in the cycle after the faulty strobe. A flag that is corrupted or wrongly updated may stay hidden until a later carry-consuming operation (add with carry, rotate through carry, decimal adjust) turns it into a wrong accumulator value. For that reason flags are compared on every clock and not only when they are consumed. A stale digit carry in particular shows up only at the next decimal adjust, as a spurious 06h correction.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 5'd0,
    OP_ADD  = 5'd1,
    OP_ADDC = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_SWAP = 5'd10,
    OP_RL   = 5'd11,
    OP_RLC  = 5'd12,
    OP_RR   = 5'd13,
    OP_RRC  = 5'd14,
    OP_DA   = 5'd15,
    OP_XCHD = 5'd16
  } acc_op_e;
endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              half_cout
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0] full;
  logic [NIB_W:0]  low;

  always_comb begin
    full      = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    low       = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    sum       = full[DATA_W-1:0];
    cout      = full[DATA_W];
    half_cout = low[NIB_W];
  end
endmodule

// File: rtl/acc_decimal_adjust.sv
module acc_decimal_adjust #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              cin,
  input  logic              aux_in,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX = (DATA_W+1)'(6) << NIB_W;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);

  logic [DATA_W:0] step1, step2;
  logic            fix_lo, fix_hi;

  always_comb begin
    fix_lo = (a[NIB_W-1:0] > DIGIT_MAX) || aux_in;
    step1  = {1'b0, a} + (fix_lo ? LO_FIX : '0);
    fix_hi = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) || cin || step1[DATA_W];
    step2  = {1'b0, step1[DATA_W-1:0]} + (fix_hi ? HI_FIX : '0);
    res    = step2[DATA_W-1:0];
    cout   = cin | step1[DATA_W] | step2[DATA_W];
  end
endmodule

// File: rtl/acc_shift_logic.sv
module acc_shift_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  acc_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              rot_cout
);
  localparam int NIB_W = DATA_W / 2;

  always_comb begin
    res      = a;
    rot_cout = cin;
    unique case (op)
      OP_LOAD: res = b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_INC:  res = a + DATA_W'(1);
      OP_DEC:  res = a - DATA_W'(1);
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_SWAP: res = {a[NIB_W-1:0], a[DATA_W-1:NIB_W]};
      OP_RL:   res = {a[DATA_W-2:0], a[DATA_W-1]};
      OP_RR:   res = {a[0], a[DATA_W-1:1]};
      OP_RLC: begin
        res      = {a[DATA_W-2:0], cin};
        rot_cout = a[DATA_W-1];
      end
      OP_RRC: begin
        res      = {cin, a[DATA_W-1:1]};
        rot_cout = a[0];
      end
      OP_XCHD: res = {a[DATA_W-1:NIB_W], b[NIB_W-1:0]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_q,
  output logic              carry_q,
  output logic              aux_q,
  output logic              acc_zero,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we
);
  localparam int NIB_W = DATA_W / 2;

  acc_op_e op;
  assign op = acc_op_e'(op_sel);

  logic [DATA_W-1:0] add_sum, da_res, sl_res;
  logic              add_c, add_hc, da_c, sl_c;
  logic              use_cin;

  assign use_cin = (op == OP_ADDC) ? carry_q : 1'b0;

  acc_adder #(.DATA_W(DATA_W)) u_add (
    .a(acc_q), .b(operand), .cin(use_cin),
    .sum(add_sum), .cout(add_c), .half_cout(add_hc)
  );

  acc_decimal_adjust #(.DATA_W(DATA_W)) u_da (
    .a(acc_q), .cin(carry_q), .aux_in(aux_q),
    .res(da_res), .cout(da_c)
  );

  acc_shift_logic #(.DATA_W(DATA_W)) u_sl (
    .op(op), .a(acc_q), .b(operand), .cin(carry_q),
    .res(sl_res), .rot_cout(sl_c)
  );

  logic [DATA_W-1:0] acc_d;
  logic              carry_d, aux_d, known_op;

  always_comb begin
    acc_d    = acc_q;
    carry_d  = carry_q;
    aux_d    = aux_q;
    known_op = (op_sel <= OP_W'(OP_XCHD));
    if (op == OP_ADD || op == OP_ADDC) begin
      acc_d   = add_sum;
      carry_d = add_c;
      aux_d   = add_hc;
    end else if (op == OP_DA) begin
      acc_d   = da_res;
      carry_d = da_c;
    end else if (known_op) begin
      acc_d   = sl_res;
      carry_d = sl_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      carry_q   <= 1'b0;
      aux_q     <= 1'b0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we <= ld_en && (op == OP_XCHD);
      if (ld_en) begin
        acc_q   <= acc_d;
        carry_q <= carry_d;
        aux_q   <= aux_d;
        if (op == OP_XCHD)
          ram_wdata <= {operand[DATA_W-1:NIB_W], acc_q[NIB_W-1:0]};
      end
    end
  end

  assign acc_zero = (acc_q == '0);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] acc_q,
  input logic              carry_q,
  input logic              aux_q,
  input logic              ram_we
);
  localparam int NIB_W = DATA_W / 2;

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(acc_q) && $stable(carry_q) && $stable(aux_q));

  a_r8_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == OP_XCHD) |=> ram_we);

  a_r9_we_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && op_sel == OP_XCHD) |=> !ram_we);

  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == OP_XCHD) |=> acc_q[DATA_W-1:NIB_W] == $past(acc_q[DATA_W-1:NIB_W]));

  a_r3_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel >= OP_W'(OP_AND) && op_sel <= OP_W'(OP_CPL))
      |=> $stable(carry_q) && $stable(aux_q));

  a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == OP_SWAP)
      |=> acc_q == {$past(acc_q[NIB_W-1:0]), $past(acc_q[DATA_W-1:NIB_W])});

  a_r5_rotl: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == OP_RL)
      |=> acc_q == {$past(acc_q[DATA_W-2:0]), $past(acc_q[DATA_W-1])});

  a_r6_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_sel == OP_RLC) |=> carry_q == $past(acc_q[DATA_W-1]));
endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_sel(op_sel),
  .acc_q(acc_q), .carry_q(carry_q), .aux_q(aux_q), .ram_we(ram_we)
);

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb;
  localparam int C_LOAD = 0, C_ADD = 1, C_ADDC = 2, C_AND = 3, C_OR = 4, C_XOR = 5,
                 C_INC = 6, C_DEC = 7, C_CLR = 8, C_CPL = 9, C_SWAP = 10, C_RL = 11,
                 C_RLC = 12, C_RR = 13, C_RRC = 14, C_DA = 15, C_XCHD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0;
  logic [4:0] op_sel = '0;
  logic [7:0] operand = '0;
  logic [7:0] acc_q, ram_wdata;
  logic       carry_q, aux_q, acc_zero, ram_we;

  always #4 clk = ~clk;

  acc_alu_core u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_sel(op_sel), .operand(operand),
    .acc_q(acc_q), .carry_q(carry_q), .aux_q(aux_q), .acc_zero(acc_zero),
    .ram_wdata(ram_wdata), .ram_we(ram_we)
  );

  int m_a = 0, m_c = 0, m_ac = 0, m_we = 0, m_wd = 0;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic check_all(input string tag);
    int act, exp;
    act = {acc_q, 7'(0), carry_q, aux_q, acc_zero, ram_we};
    exp = {m_a[7:0], 7'(0), m_c[0], m_ac[0], (m_a == 0) ? 1'b1 : 1'b0, m_we[0]};
    checks++;
    if (act != exp || (m_we != 0 && ram_wdata != m_wd[7:0])) begin
      fails++;
      $display("FAIL %s: acc/c/ac/z/we=%h wd=%h expected %h wd=%h", tag, act, ram_wdata, exp, m_wd);
    end
  endtask

  function automatic void model(input int o, input int b, input bit ld);
    int t, ov;
    m_we = 0;
    if (!ld || o > C_XCHD) return;
    case (o)
      C_LOAD: m_a = b;
      C_ADD, C_ADDC: begin
        t = (o == C_ADDC) ? m_c : 0;
        m_ac = ((m_a % 16) + (b % 16) + t) > 15;
        t = m_a + b + t;
        m_c = t > 255;
        m_a = t % 256;
      end
      C_AND: m_a = m_a & b;
      C_OR:  m_a = m_a | b;
      C_XOR: m_a = m_a ^ b;
      C_INC: m_a = (m_a + 1) % 256;
      C_DEC: m_a = (m_a + 255) % 256;
      C_CLR: m_a = 0;
      C_CPL: m_a = 255 - m_a;
      C_SWAP: m_a = (m_a % 16) * 16 + m_a / 16;
      C_RL:  m_a = (m_a * 2) % 256 + m_a / 128;
      C_RR:  m_a = m_a / 2 + (m_a % 2) * 128;
      C_RLC: begin t = m_a / 128; m_a = (m_a * 2) % 256 + m_c; m_c = t; end
      C_RRC: begin t = m_a % 2; m_a = m_a / 2 + m_c * 128; m_c = t; end
      C_DA: begin
        t = m_a;
        if (t % 16 > 9 || m_ac != 0) t += 6;
        ov = t > 255;
        t = t % 256;
        if (t / 16 > 9 || m_c != 0 || ov != 0) t += 96;
        if (t > 255 || ov != 0) m_c = 1;
        m_a = t % 256;
      end
      C_XCHD: begin
        m_wd = (b / 16) * 16 + m_a % 16;
        m_a  = (m_a / 16) * 16 + b % 16;
        m_we = 1;
      end
      default: ;
    endcase
  endfunction

  task automatic step(input int o, input int b, input bit ld, input string tag);
    op_sel = o[4:0]; operand = b[7:0]; ld_en = ld;
    model(o, b, ld);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected <=100000", cycles);
      finish_run();
    end
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    check_all("R1 reset held");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");
    // R2 plain and with carry
    step(C_LOAD, 8'h38, 1, "R3 load");
    step(C_ADD, 8'h49, 1, "R2 add 38+49");
    step(C_DA, 0, 1, "R7 da to 87");
    step(C_LOAD, 8'h99, 1, "R3 load");
    step(C_ADD, 8'h01, 1, "R2 add 99+01");
    step(C_DA, 0, 1, "R7 da wrap C");
    step(C_ADDC, 8'hFF, 1, "R2 addc carry in");
    step(C_LOAD, 8'hFF, 1, "R3 load");
    step(C_DA, 0, 1, "R7 da FF");
    step(C_ADD, 8'hFF, 1, "R2 add carry out");
    step(C_ADDC, 8'h10, 1, "R2 addc");
    // R3 logic and unary
    step(C_AND, 8'h3C, 1, "R3 and");
    step(C_OR, 8'hA1, 1, "R3 or");
    step(C_XOR, 8'hFF, 1, "R3 xor");
    step(C_LOAD, 8'hFF, 1, "R3 load");
    step(C_INC, 0, 1, "R3 inc wrap R10 zero");
    step(C_DEC, 0, 1, "R3 dec wrap");
    step(C_CLR, 0, 1, "R3 clr R10");
    step(C_CPL, 0, 1, "R3 cpl");
    // R4 R5 R6
    step(C_LOAD, 8'h96, 1, "R3 load");
    step(C_SWAP, 0, 1, "R4 swap");
    step(C_RL, 0, 1, "R5 rl");
    step(C_RR, 0, 1, "R5 rr");
    step(C_RLC, 0, 1, "R6 rlc");
    step(C_RLC, 0, 1, "R6 rlc");
    step(C_RRC, 0, 1, "R6 rrc");
    step(C_RRC, 0, 1, "R6 rrc");
    // R8 nibble exchange
    step(C_LOAD, 8'h5A, 1, "R3 load");
    step(C_XCHD, 8'hC3, 1, "R8 xchd");
    step(C_XCHD, 8'h7E, 0, "R9 no strobe we low");
    // R9 no strobe and unused codes
    step(C_CLR, 0, 0, "R9 idle clr");
    step(C_ADD, 8'h80, 0, "R9 idle add");
    step(20, 8'h11, 1, "R9 unused code");
    step(31, 8'h22, 1, "R9 unused code");
    // R11 subtract identity
    step(C_LOAD, 8'h50, 1, "R11 load");
    step(C_CPL, 0, 1, "R11 cpl");
    step(C_ADD, 8'h23, 1, "R11 add");
    step(C_CPL, 0, 1, "R11 cpl");
    checks++;
    if (acc_q != 8'h2D) begin
      fails++;
      $display("FAIL R11 subtract: acc=%h expected 2d", acc_q);
    end
    // random mix
    seed = 12345;
    for (int i = 0; i < 400; i++) begin
      int o, b;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      o = (seed / 256) % 17;
      b = (seed / 65536) % 256;
      step(o, b, (seed % 8) != 0, "R2-mix random");
    end
    finish_run();
  end
endmodule